// File: doc/BRIEF.md
# Coherence Transaction Completion Tracker

This block keeps a small table of the coherence transactions that a last-level cache controller has in flight. A transaction starts when the controller sends an update to a set of registered copies, or sends an invalidate to a set of copies, or broadcasts an invalidate because only a copy count is known. At that point the block takes a free slot. The slot records the transaction kind, the cache line and the number of answers still expected. The slot index is returned as the transaction index.

Answers reduce the count of their slot. An update acknowledgement names its slot by transaction index. A cleanup names only a cache line, so it is matched against the invalidate slots. When the last expected answer is consumed, the block raises a completion pulse that carries the index, the line and the kind, and it frees the slot at the same clock edge.

Every accepted cleanup also queues a request to send a cleanup-acknowledge back to the L1 that sent it. This happens whether or not the cleanup matched a slot. The requests wait in a small FIFO, so a stalled response port loses none of them. When the FIFO is full, the cleanup input is stalled.

Top module: `coh_txn_tracker`

## Requirements
- R1: When `alloc_valid` is high and a slot is free, the lowest-numbered free slot is taken and its number appears on `alloc_idx` in the same cycle. `alloc_full` is high exactly when every slot is occupied, and a request made while full has no effect.
- R2: The kind encoding on `alloc_kind` and `done_kind` is 0 for multicast update, 1 for multicast invalidate and 2 for broadcast invalidate.
- R3: An accepted update acknowledgement whose `ack_idx` names an occupied update slot decrements that slot's count. On the acknowledgement that finds a count of 1, `done_valid` pulses combinationally with that slot's index, line and kind. The slot is free from the next cycle.
- R4: An update acknowledgement that names a free slot, or a slot of an invalidate kind, changes no count and raises no completion.
- R5: An accepted cleanup decrements the lowest-numbered occupied invalidate slot (kind 1 or 2) whose line equals `cln_line`. On the cleanup that finds a count of 1, the completion pulse is raised as in R3.
- R6: A cleanup whose line matches no invalidate slot changes no count and raises no completion, but still gets a cleanup-acknowledge request.
- R7: Each accepted cleanup places its `cln_src` in the acknowledge FIFO, and `clack_valid` is high from the next cycle. Requests leave in arrival order.
- R8: While `clack_valid` is high and `clack_ready` is low, `clack_src` holds its value. `cln_ready` is low exactly when the FIFO holds DEPTH entries, so no request is lost.
- R9: A cleanup takes priority over an update acknowledgement. `ack_ready` is low in any cycle where `cln_valid` is high.
- R10: After reset, all slots are free, `alloc_full`, `done_valid` and `clack_valid` are low, and `alloc_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Start a transaction |
| alloc_kind | input | 2 | Transaction kind (R2) |
| alloc_line | input | LINE_W | Cache line of the transaction |
| alloc_count | input | CNT_W | Answers expected, at least 1 |
| alloc_full | output | 1 | No free slot |
| alloc_idx | output | IDX_W | Slot assigned to the request |
| ack_valid | input | 1 | Update acknowledgement present |
| ack_idx | input | IDX_W | Transaction index of the acknowledgement |
| ack_ready | output | 1 | Acknowledgement accepted this cycle |
| cln_valid | input | 1 | Cleanup present |
| cln_line | input | LINE_W | Line named by the cleanup |
| cln_src | input | SRC_W | L1 that sent the cleanup |
| cln_ready | output | 1 | Cleanup accepted this cycle |
| done_valid | output | 1 | Completion pulse |
| done_idx | output | IDX_W | Index of the completed transaction |
| done_line | output | LINE_W | Line of the completed transaction |
| done_kind | output | 2 | Kind of the completed transaction |
| clack_valid | output | 1 | Cleanup-acknowledge request pending |
| clack_src | output | SRC_W | L1 to be acknowledged |
| clack_ready | input | 1 | Response port takes the request |

## Verification
Slot allocation is swept across every slot of a four-slot table. Each slot gets a different expected count, so the bench tells apart a completion on the correct final acknowledgement from one that comes early or late. Acknowledgements sent to free slots and to invalidate slots show that only update slots react to an index. The cleanup patterns mix matching lines of both invalidate kinds with a line that matches nothing, and they arrive while the response port is stalled. This separates line matching from acknowledge queuing and exposes any loss or reordering at a full FIFO. A simultaneous acknowledgement and cleanup checks the arbitration.

// File: rtl/coh_txn_tracker.sv
module coh_txn_tracker #(
  parameter int SLOTS  = 4,
  parameter int LINE_W = 16,
  parameter int CNT_W  = 4,
  parameter int SRC_W  = 4,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [CNT_W-1:0]  alloc_count,
  output logic              alloc_full,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic              ack_ready,
  input  logic              cln_valid,
  input  logic [LINE_W-1:0] cln_line,
  input  logic [SRC_W-1:0]  cln_src,
  output logic              cln_ready,
  output logic              done_valid,
  output logic [IDX_W-1:0]  done_idx,
  output logic [LINE_W-1:0] done_line,
  output logic [1:0]        done_kind,
  output logic              clack_valid,
  output logic [SRC_W-1:0]  clack_src,
  input  logic              clack_ready
);
  localparam logic [1:0] K_UPD = 2'd0;

  logic [SLOTS-1:0]  vld;
  logic [1:0]        kind [SLOTS];
  logic [LINE_W-1:0] line [SLOTS];
  logic [CNT_W-1:0]  cnt  [SLOTS];

  logic             free_hit, cl_hit;
  logic [IDX_W-1:0] free_idx, cl_idx;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    cl_hit   = 1'b0;
    cl_idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (vld[i] && kind[i] != K_UPD && line[i] == cln_line) begin
        cl_hit = 1'b1;
        cl_idx = IDX_W'(i);
      end
    end
  end

  assign alloc_full = !free_hit;
  assign alloc_idx  = free_idx;
  assign ack_ready  = !cln_valid;

  wire alloc_fire = alloc_valid && free_hit;
  wire ack_fire   = ack_valid && ack_ready && vld[ack_idx] && kind[ack_idx] == K_UPD;
  wire cln_fire   = cln_valid && cln_ready;
  wire cln_match  = cln_fire && cl_hit;
  wire cln_done   = cln_match && cnt[cl_idx] == CNT_W'(1);
  wire ack_done   = ack_fire && cnt[ack_idx] == CNT_W'(1);

  assign done_valid = cln_done || ack_done;
  assign done_idx   = cln_done ? cl_idx : ack_idx;
  assign done_line  = line[done_idx];
  assign done_kind  = kind[done_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        kind[i] <= '0;
        line[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      if (alloc_fire) begin
        vld[free_idx]  <= 1'b1;
        kind[free_idx] <= alloc_kind;
        line[free_idx] <= alloc_line;
        cnt[free_idx]  <= alloc_count;
      end
      if (cln_match) begin
        if (cln_done) vld[cl_idx] <= 1'b0;
        else          cnt[cl_idx] <= cnt[cl_idx] - CNT_W'(1);
      end
      if (ack_fire) begin
        if (ack_done) vld[ack_idx] <= 1'b0;
        else          cnt[ack_idx] <= cnt[ack_idx] - CNT_W'(1);
      end
    end
  end

  // cleanup-acknowledge queue
  logic [SRC_W-1:0] fq [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W:0]   fcnt;
  wire pop = clack_valid && clack_ready;

  assign cln_ready   = fcnt != (PTR_W+1)'(DEPTH);
  assign clack_valid = fcnt != '0;
  assign clack_src   = fq[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fcnt <= '0;
      for (int i = 0; i < DEPTH; i++) fq[i] <= '0;
    end else begin
      if (cln_fire) begin
        fq[wp] <= cln_src;
        wp     <= wp + PTR_W'(1);
      end
      if (pop) rp <= rp + PTR_W'(1);
      fcnt <= fcnt + (PTR_W+1)'(cln_fire) - (PTR_W+1)'(pop);
    end
  end

  p_alloc_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_full |=> vld[$past(alloc_idx)]);
  p_done_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !vld[$past(done_idx)]);
  p_clack_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cln_valid && cln_ready |=> clack_valid);
  p_clack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clack_valid && !clack_ready |=> clack_valid && $stable(clack_src));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= (PTR_W+1)'(DEPTH));
  p_arb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && cln_valid |=> !$past(ack_ready));

  for (genvar g = 0; g < SLOTS; g++) begin : g_cnt_chk
    p_live_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vld[g] |-> cnt[g] != '0);
  end
endmodule

// File: tb/tb_coh_txn_tracker.sv
module tb_coh_txn_tracker;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic alloc_valid = 0, ack_valid = 0, cln_valid = 0, clack_ready = 0;
  logic [1:0] alloc_kind = 0;
  logic [15:0] alloc_line = 0, cln_line = 0;
  logic [3:0] alloc_count = 0, cln_src = 0;
  logic [1:0] ack_idx = 0;
  logic alloc_full, ack_ready, cln_ready, done_valid, clack_valid;
  logic [1:0] alloc_idx, done_idx, done_kind;
  logic [15:0] done_line;
  logic [3:0] clack_src;

  coh_txn_tracker dut (.*);

  int errors = 0, checks = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alloc(int k, int ln, int c, int exp_idx, string req);
    @(negedge clk);
    alloc_valid = 1; alloc_kind = 2'(k); alloc_line = 16'(ln); alloc_count = 4'(c);
    #1 chk(!alloc_full && alloc_idx == 2'(exp_idx), req, alloc_idx, exp_idx);
    @(posedge clk); #1 alloc_valid = 0;
  endtask

  task automatic ack(int idx, bit exp_done, int ln, string req);
    @(negedge clk);
    ack_valid = 1; ack_idx = 2'(idx);
    #1 chk(done_valid == exp_done, req, done_valid, exp_done);
    if (exp_done) begin
      chk(done_idx == 2'(idx) && done_line == 16'(ln), req, done_line, ln);
      chk(done_kind == 2'd0, "R2", done_kind, 0);
    end
    @(posedge clk); #1 ack_valid = 0;
  endtask

  task automatic cln(int ln, int src, bit exp_done, int idx, int k, string req);
    @(negedge clk);
    cln_valid = 1; cln_line = 16'(ln); cln_src = 4'(src);
    #1 chk(cln_ready == 1, "R8", cln_ready, 1);
    chk(done_valid == exp_done, req, done_valid, exp_done);
    if (exp_done) begin
      chk(done_idx == 2'(idx) && done_line == 16'(ln), req, done_idx, idx);
      chk(done_kind == 2'(k), "R2", done_kind, k);
    end
    @(posedge clk); #1 cln_valid = 0;
  endtask

  task automatic pop(int exp);
    @(negedge clk);
    #1 chk(clack_valid && clack_src == 4'(exp), "R7", clack_src, exp);
    clack_ready = 1;
    @(posedge clk); #1 clack_ready = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!alloc_full && !done_valid && !clack_valid && alloc_idx == 0, "R10", alloc_full, 0);

    for (int i = 0; i < 4; i++) alloc(0, 'h100 + i * 7, i + 1, i, "R1");
    @(negedge clk);
    chk(alloc_full == 1, "R1", alloc_full, 1);
    alloc_valid = 1; alloc_kind = 1; alloc_line = 'h55; alloc_count = 1;
    @(posedge clk); #1 alloc_valid = 0;
    @(negedge clk);
    chk(alloc_full == 1, "R1", alloc_full, 1);

    for (int i = 0; i < 4; i++) begin
      for (int k = 1; k <= i + 1; k++) ack(i, k == i + 1, 'h100 + i * 7, "R3");
      @(negedge clk);
      chk(alloc_full == 0, "R3", alloc_full, 0);
      ack(i, 0, 0, "R4");
    end
    // the request refused while full left no slot behind
    cln('h55, 9, 0, 0, 0, "R1");

    alloc(1, 'h55, 3, 0, "R1");
    alloc(2, 'h66, 2, 1, "R1");
    ack(0, 0, 0, "R4");
    ack(1, 0, 0, "R4");
    pop(9);

    @(negedge clk);
    cln_valid = 1; cln_line = 'h55; cln_src = 1; ack_valid = 1; ack_idx = 0;
    #1 chk(ack_ready == 0, "R9", ack_ready, 0);
    @(posedge clk); #1 cln_valid = 0; ack_valid = 0;
    cln('h77, 2, 0, 0, 0, "R6");
    cln('h55, 3, 0, 0, 0, "R5");
    cln('h66, 4, 0, 0, 0, "R5");
    @(negedge clk);
    chk(cln_ready == 0, "R8", cln_ready, 0);
    chk(clack_valid && clack_src == 1, "R8", clack_src, 1);
    @(negedge clk);
    chk(clack_src == 1, "R8", clack_src, 1);
    for (int s = 1; s <= 4; s++) pop(s);

    cln('h55, 5, 1, 0, 1, "R5");
    cln('h66, 6, 1, 1, 2, "R5");
    pop(5);
    pop(6);
    @(negedge clk);
    chk(!clack_valid && !alloc_full, "R7", clack_valid, 0);
    cln('h55, 7, 0, 0, 0, "R6");
    pop(7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule